// File: doc/BRIEF.md
# Register Rename Map with Squash Recovery

This block turns architectural register numbers into physical register numbers for one instruction per cycle. Each physical register carries a binding: the architectural register it belongs to and a flag that says whether it is the current mapping. A source lookup searches those bindings associatively. An instruction that writes a register gets a newly allocated physical register, so every write has its own storage. The block also reports the physical register that held the old value of that destination.

Each accepted instruction takes the next slot of a 32-entry circular sequence window. For that slot the block keeps a copy of the mapping flags as they stood before the rename, together with the new register and the stale register. The stale register goes back to the free list only when its instruction retires, and retirement is always in order from the oldest slot.

A squash names the oldest sequence index to discard. The mapping returns to the snapshot taken just before that instruction was renamed, and every physical register the discarded instructions allocated is free again on the next cycle.

The request side is a valid/ready handshake. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable until it is accepted. The response fields are combinational and belong to the request in the same cycle as the handshake. Retire and squash are plain control pins.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i below 32, physical registers 32 to 63 are free, `req_ready` is high, and the first allocation returns physical register 32.
- R2: `rsp_psrc1` and `rsp_psrc2` give the current mapping of `req_src1` and `req_src2`. The lookup sees the map as it was before the same instruction's destination update.
- R3: An accepted request with `req_has_dst` high receives the lowest-numbered free physical register on `rsp_pdst`. `rsp_pold` gives the previous mapping of `req_dst`. From the next cycle on, `req_dst` maps to `rsp_pdst`.
- R4: An accepted request with `req_has_dst` low allocates no register, leaves the map unchanged and records no stale register.
- R5: `req_ready` is low while the free list is empty, while 32 instructions are in flight, or while `sq_valid` is high. A request that is not accepted changes nothing.
- R6: A high `ret_valid` retires the oldest in-flight instruction. If that instruction had a destination, its stale register becomes free and can be allocated from the following cycle.
- R7: A squash of an in-flight index restores the map to its state just before that instruction was renamed. It frees every register allocated by that instruction and all younger ones. The next sequence index to be issued becomes the squashed index.
- R8: A retire with nothing in flight is ignored. A squash whose index is not in flight is ignored. A retire in the same cycle as `sq_valid` is ignored.
- R9: `rsp_seq` gives the sequence index of an accepted request. Indices are consecutive modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Rename request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_src1 | input | 5 | First source architectural register |
| req_src2 | input | 5 | Second source architectural register |
| req_has_dst | input | 1 | Request writes a destination register |
| req_dst | input | 5 | Destination architectural register |
| rsp_psrc1 | output | 6 | Physical register for first source |
| rsp_psrc2 | output | 6 | Physical register for second source |
| rsp_pdst | output | 6 | Newly allocated physical register (0 when no destination) |
| rsp_pold | output | 6 | Previous mapping of the destination (0 when no destination) |
| rsp_seq | output | 5 | Sequence index given to the request |
| ret_valid | input | 1 | Retire the oldest in-flight instruction |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | 5 | Oldest sequence index to discard |

## Verification
The response fields and `req_ready` are combinational and are due in the same cycle as the request. Map updates, releases and squash recovery take effect at the next rising edge and show up in the responses of the following cycle. The bench drives all inputs at the falling edge and samples one nanosecond later, well before the next rising edge. It then advances its own model of the map, free list and window exactly as the coming edge will, so each comparison lines up with the cycle in which the result is due.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  localparam int unsigned RM_ARCH_REGS = 32;
  localparam int unsigned RM_PHYS_REGS = 64;
  localparam int unsigned RM_WINDOW    = 32;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int unsigned NPHYS = 64,
  parameter int unsigned NARCH = 32,
  parameter int unsigned PW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  output logic [PW-1:0]    alloc_idx,
  output logic             any_free,
  input  logic             rel_en,
  input  logic [PW-1:0]    rel_idx,
  input  logic [NPHYS-1:0] reclaim
);
  logic [NPHYS-1:0] free_q;

  always_comb begin
    alloc_idx = '0;
    for (int p = NPHYS - 1; p >= 0; p--) begin
      if (free_q[p]) alloc_idx = PW'(p);
    end
    any_free = |free_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPHYS; p++) free_q[p] <= (p >= NARCH);
    end else begin
      for (int p = 0; p < NPHYS; p++) begin
        if (reclaim[p] || (rel_en && rel_idx == PW'(p)))
          free_q[p] <= 1'b1;
        else if (alloc_en && alloc_idx == PW'(p))
          free_q[p] <= 1'b0;
      end
    end
  end

  // R6
  no_double_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> !free_q[rel_idx]);
  // R7
  reclaim_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reclaim & free_q) == '0);
  // R5
  alloc_has_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> any_free);
endmodule

// File: rtl/rn_bind.sv
module rn_bind #(
  parameter int unsigned NARCH = 32,
  parameter int unsigned NPHYS = 64,
  parameter int unsigned NSEQ  = 32,
  parameter int unsigned AW    = 5,
  parameter int unsigned PW    = 6,
  parameter int unsigned IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src1,
  input  logic [AW-1:0] src2,
  input  logic [AW-1:0] dst,
  input  logic          upd,
  input  logic [PW-1:0] upd_new,
  input  logic          snap_we,
  input  logic [IW-1:0] snap_idx,
  input  logic          restore,
  input  logic [IW-1:0] restore_idx,
  output logic [PW-1:0] psrc1,
  output logic [PW-1:0] psrc2,
  output logic [PW-1:0] pold
);
  logic [NPHYS-1:0] cur_q;
  logic [AW-1:0]    tag_q [NPHYS];
  logic [NPHYS-1:0] snap_q [NSEQ];

  always_comb begin
    psrc1 = '0;
    psrc2 = '0;
    pold  = '0;
    for (int p = 0; p < NPHYS; p++) begin
      if (cur_q[p] && tag_q[p] == src1) psrc1 = PW'(p);
      if (cur_q[p] && tag_q[p] == src2) psrc2 = PW'(p);
      if (cur_q[p] && tag_q[p] == dst)  pold  = PW'(p);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPHYS; p++) begin
        cur_q[p] <= (p < NARCH);
        tag_q[p] <= AW'(p);
      end
    end else if (restore) begin
      cur_q <= snap_q[restore_idx];
    end else if (upd) begin
      cur_q[pold]    <= 1'b0;
      cur_q[upd_new] <= 1'b1;
      tag_q[upd_new] <= dst;
    end
  end

  always_ff @(posedge clk) begin
    if (snap_we) snap_q[snap_idx] <= cur_q;
  end

  // R2
  one_binding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cur_q) == NARCH);
  // R3
  new_unbound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> !cur_q[upd_new]);
endmodule

// File: rtl/rn_window.sv
module rn_window #(
  parameter int unsigned NSEQ  = 32,
  parameter int unsigned NPHYS = 64,
  parameter int unsigned PW    = 6,
  parameter int unsigned IW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_dst,
  input  logic [PW-1:0]    push_new,
  input  logic [PW-1:0]    push_old,
  input  logic             ret_req,
  input  logic             sq_req,
  input  logic [IW-1:0]    sq_idx,
  output logic [IW-1:0]    tail,
  output logic             full,
  output logic             rel_en,
  output logic [PW-1:0]    rel_idx,
  output logic             sq_hit,
  output logic [NPHYS-1:0] reclaim
);
  logic [IW-1:0] head_q, tail_q;
  logic [IW:0]   cnt_q;
  logic          ent_dst [NSEQ];
  logic [PW-1:0] ent_new [NSEQ];
  logic [PW-1:0] ent_old [NSEQ];
  logic [IW-1:0] d_sq;
  logic          ret_fire;

  assign tail     = tail_q;
  assign full     = (cnt_q == (IW+1)'(NSEQ));
  assign d_sq     = sq_idx - head_q;
  assign sq_hit   = sq_req && ({1'b0, d_sq} < cnt_q);
  assign ret_fire = ret_req && !sq_req && (cnt_q != '0);
  assign rel_en   = ret_fire && ent_dst[head_q];
  assign rel_idx  = ent_old[head_q];

  always_comb begin
    reclaim = '0;
    for (int i = 0; i < NSEQ; i++) begin
      logic [IW-1:0] di;
      di = IW'(i) - head_q;
      if (sq_hit && di >= d_sq && {1'b0, di} < cnt_q && ent_dst[i])
        reclaim[ent_new[i]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < NSEQ; i++) begin
        ent_dst[i] <= 1'b0;
        ent_new[i] <= '0;
        ent_old[i] <= '0;
      end
    end else if (sq_hit) begin
      tail_q <= sq_idx;
      cnt_q  <= {1'b0, d_sq};
    end else begin
      if (push) begin
        ent_dst[tail_q] <= push_dst;
        ent_new[tail_q] <= push_new;
        ent_old[tail_q] <= push_old;
        tail_q <= tail_q + 1'b1;
      end
      if (ret_fire) head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + (IW+1)'(push) - (IW+1)'(ret_fire);
    end
  end

  // R5
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (IW+1)'(NSEQ));
  // R5
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full && !sq_req);
  // R7
  squash_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_hit |=> tail_q == $past(sq_idx) && cnt_q == {1'b0, $past(d_sq)});
  // R9
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> tail_q == $past(tail_q) + 1'b1);
endmodule

// File: rtl/rename_map.sv
module rename_map #(
  parameter int unsigned NARCH = rmap_pkg::RM_ARCH_REGS,
  parameter int unsigned NPHYS = rmap_pkg::RM_PHYS_REGS,
  parameter int unsigned NSEQ  = rmap_pkg::RM_WINDOW,
  localparam int unsigned AW   = $clog2(NARCH),
  localparam int unsigned PW   = $clog2(NPHYS),
  localparam int unsigned IW   = $clog2(NSEQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_src1,
  input  logic [AW-1:0] req_src2,
  input  logic          req_has_dst,
  input  logic [AW-1:0] req_dst,
  output logic [PW-1:0] rsp_psrc1,
  output logic [PW-1:0] rsp_psrc2,
  output logic [PW-1:0] rsp_pdst,
  output logic [PW-1:0] rsp_pold,
  output logic [IW-1:0] rsp_seq,
  input  logic          ret_valid,
  input  logic          sq_valid,
  input  logic [IW-1:0] sq_seq
);
  logic             win_full, any_free, fire, alloc_en;
  logic             rel_en, sq_hit;
  logic [PW-1:0]    alloc_idx, rel_idx, pold;
  logic [NPHYS-1:0] reclaim;
  logic [IW-1:0]    tail;

  assign req_ready = !win_full && any_free && !sq_valid;
  assign fire      = req_valid && req_ready;
  assign alloc_en  = fire && req_has_dst;
  assign rsp_pdst  = req_has_dst ? alloc_idx : '0;
  assign rsp_pold  = req_has_dst ? pold : '0;
  assign rsp_seq   = tail;

  rn_freelist #(.NPHYS(NPHYS), .NARCH(NARCH), .PW(PW)) u_free (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .any_free(any_free), .rel_en(rel_en), .rel_idx(rel_idx), .reclaim(reclaim));

  rn_bind #(.NARCH(NARCH), .NPHYS(NPHYS), .NSEQ(NSEQ), .AW(AW), .PW(PW), .IW(IW)) u_bind (
    .clk(clk), .rst_n(rst_n), .src1(req_src1), .src2(req_src2), .dst(req_dst),
    .upd(alloc_en), .upd_new(alloc_idx), .snap_we(fire), .snap_idx(tail),
    .restore(sq_hit), .restore_idx(sq_seq),
    .psrc1(rsp_psrc1), .psrc2(rsp_psrc2), .pold(pold));

  rn_window #(.NSEQ(NSEQ), .NPHYS(NPHYS), .PW(PW), .IW(IW)) u_win (
    .clk(clk), .rst_n(rst_n), .push(fire), .push_dst(req_has_dst),
    .push_new(alloc_idx), .push_old(pold), .ret_req(ret_valid),
    .sq_req(sq_valid), .sq_idx(sq_seq), .tail(tail), .full(win_full),
    .rel_en(rel_en), .rel_idx(rel_idx), .sq_hit(sq_hit), .reclaim(reclaim));

  // R3
  fresh_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> rsp_pdst != rsp_pold);
  // R4
  nodst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_has_dst) |-> rsp_pdst == '0 && rsp_pold == '0);
endmodule

// File: tb/sim_rename_map.sv
`timescale 1ns/1ps
module sim_rename_map;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_has_dst = 1'b0, ret_valid = 1'b0, sq_valid = 1'b0;
  logic [4:0] req_src1 = '0, req_src2 = '0, req_dst = '0, sq_seq = '0;
  logic       req_ready;
  logic [5:0] rsp_psrc1, rsp_psrc2, rsp_pdst, rsp_pold;
  logic [4:0] rsp_seq;

  int errs = 0, checks = 0, cyc = 0;
  int mmap [32];
  bit mfree [64];
  bit wdst [32];
  int wnew [32], wold [32];
  int snap [32][32];
  int head, tail, cnt;

  always #4 clk = ~clk;

  rename_map u0 (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int p = 0; p < 64; p++) if (mfree[p]) return p;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mmap[i] = i;
    for (int p = 0; p < 64; p++) mfree[p] = (p >= 32);
    head = 0; tail = 0; cnt = 0;
  endtask

  task automatic step(input bit v, input int s1, input int s2, input bit hd, input int d,
                      input bit rv, input bit sv, input int sidx, input string tg = "");
    bit er, fire;
    int lf, cb, ds;
    @(negedge clk);
    req_valid = v; req_src1 = 5'(s1); req_src2 = 5'(s2); req_has_dst = hd;
    req_dst = 5'(d); ret_valid = rv; sq_valid = sv; sq_seq = 5'(sidx);
    #1;
    lf = lowest_free();
    er = (cnt < 32) && (lf >= 0) && !sv;
    check((tg != "") ? tg : "R5", int'(req_ready), int'(er));
    fire = v && er;
    if (fire) begin
      check((tg != "") ? tg : "R2", int'(rsp_psrc1), mmap[s1]);
      check((tg != "") ? tg : "R2", int'(rsp_psrc2), mmap[s2]);
      check((tg != "") ? tg : "R9", int'(rsp_seq), tail);
      if (hd) begin
        check((tg != "") ? tg : "R3", int'(rsp_pdst), lf);
        check((tg != "") ? tg : "R3", int'(rsp_pold), mmap[d]);
      end else begin
        check((tg != "") ? tg : "R4", int'(rsp_pdst), 0);
      end
    end
    if (sv) begin
      ds = (sidx - head) & 31;
      if (ds < cnt) begin
        for (int k = ds; k < cnt; k++) begin
          int e;
          e = (head + k) & 31;
          if (wdst[e]) mfree[wnew[e]] = 1'b1;
        end
        for (int i = 0; i < 32; i++) mmap[i] = snap[sidx][i];
        tail = sidx; cnt = ds;
      end
    end else begin
      cb = cnt;
      if (fire) begin
        for (int i = 0; i < 32; i++) snap[tail][i] = mmap[i];
        wdst[tail] = hd;
        if (hd) begin
          wnew[tail] = lf; wold[tail] = mmap[d];
          mfree[lf] = 1'b0; mmap[d] = lf;
        end
        tail = (tail + 1) & 31; cnt++;
      end
      if (rv && cb > 0) begin
        if (wdst[head]) mfree[wold[head]] = 1'b1;
        head = (head + 1) & 31; cnt--;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20251));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset map and first allocation
    step(1, 0, 31, 1, 3, 0, 0, 0, "R1");
    // R2: sources see map before own destination update
    step(1, 3, 3, 1, 3, 0, 0, 0, "R2");
    // R4: no destination, next allocation unchanged
    step(1, 3, 1, 0, 0, 0, 0, 0, "R4");
    step(1, 3, 3, 1, 7, 0, 0, 0, "R4");
    // R6: retire frees stale registers, lowest reused next
    step(0, 0, 0, 0, 0, 1, 0, 0, "R6");
    step(1, 2, 3, 1, 9, 0, 0, 0, "R6");
    // R8: squash of index not in flight, retire during squash
    step(0, 0, 0, 0, 0, 0, 1, 20, "R8");
    step(1, 3, 9, 1, 3, 1, 1, 25, "R8");
    step(1, 3, 9, 1, 4, 0, 0, 0, "R8");
    // R7: squash in middle of window
    for (int i = 0; i < 4; i++) step(1, i, 4, 1, 4, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, (tail - 3) & 31, "R7");
    step(1, 4, 3, 1, 4, 0, 0, 0, "R7");
    // drain everything
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, 1, 0, 0, "R8");
    // R5: fill window with no-destination requests
    for (int i = 0; i < 33; i++) step(1, i & 31, 5, 0, 0, 0, 0, 0, "R5");
    step(1, 1, 2, 1, 1, 1, 0, 0, "R5");
    step(1, 1, 2, 1, 1, 0, 0, 0, "R5");
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, 1, 0, 0, "R6");
    // R5: exhaust free list with destinations
    for (int i = 0; i < 34; i++) step(1, 6, 7, 1, i & 31, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 1, head, "R7");
    step(1, 5, 6, 1, 5, 0, 0, 0, "R7");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r, si;
      bit sv;
      r  = $urandom % 100;
      sv = (r < 3);
      si = (cnt > 0 && ($urandom % 4 != 0)) ? ((head + $urandom % cnt) & 31) : $urandom % 32;
      step(($urandom % 10) < 7, $urandom % 32, $urandom % 32, ($urandom % 10) < 8,
           $urandom % 32, ($urandom % 10) < 3, sv, si);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule